// File: doc/BRIEF.md
# Register-Mapped Bidirectional Port Unit

This unit gives a small microcontroller two general-purpose pin groups: an 8-line group A and a 3-line group B. Each group has a data latch and a direction register, both reached over a byte-wide internal register bus. The unit drives per-line output-enable, output-value and pull-up-enable signals toward the pads. It brings the pad levels in through a synchronizer. A read of a data register returns the synchronized pad level for lines set as inputs and the latch for lines set as outputs. Because of this, a read-modify-write bit operation on the data register leaves driven lines unchanged.

Any group A line that is an input and has its wake option set raises a one-cycle wake request when it falls. The bus is a single-cycle register port: there is no valid/ready handshake and no back-pressure. A write strobe is always accepted on the clock edge where it is high. Read data is a combinational function of the address and the current state. Pull-ups are chosen per group by a parameter and are switched on only for lines that are inputs.

Top module: `gpio_port_unit`

## Requirements
- R1: The register map is: group A data at 0x12, group A direction at 0x13, group B data at 0x14, group B direction at 0x15.
- R2: A direction bit of 1 makes the line an input (output-enable 0) and a bit of 0 makes it an output (output-enable 1). A write changes the output-enables from the clock edge that takes the write strobe. A direction register reads back the value last written.
- R3: A data-register read returns, bit by bit, the synchronized pad level where the direction bit is 1 and the latch value where it is 0.
- R4: The output-value pins show the data latch. The latch changes only on a write to its own data address.
- R5: Reset (rst_n low, asynchronous) sets every direction bit and every latch bit to 1, which gives output-enable 0, output-value 1 and no wake request.
- R6: Group B has lines 0 to 2 only. Bits 7..3 of addresses 0x14 and 0x15 read 0, and writes to those bits have no effect.
- R7: Pad inputs pass through two flops. A pad level set up before clock edge k appears in data reads after edge k+1.
- R8: wake_req is a registered one-cycle pulse per event. It goes high after the edge that follows the cycle in which some synchronized group A line with direction 1 and wake_en 1 goes from 1 to 0.
- R9: The pull-up-enable of a line equals its group's pull option parameter AND its direction bit.
- R10: Writes to any address outside 0x12..0x15 change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pa_in | input | 8 | Group A pad levels |
| pa_oe | output | 8 | Group A output enables |
| pa_out | output | 8 | Group A output values |
| pa_pu | output | 8 | Group A pull-up enables |
| pb_in | input | 3 | Group B pad levels |
| pb_oe | output | 3 | Group B output enables |
| pb_out | output | 3 | Group B output values |
| pb_pu | output | 3 | Group B pull-up enables |
| wake_en | input | 8 | Per-line wake option for group A |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The assertions check on every cycle that:
- a direction write lands on the output-enables one edge later;
- latches hold between writes;
- group B's missing bits and unmapped addresses read zero;
- no wake request appears while every wake option has been off.

Only the bench's scenarios can show:
- the per-bit choice between pad and latch on reads;
- the two-edge pad latency;
- the exact cycle of a wake pulse after a falling pad;
- the reset values seen from the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_A_DATA,
    SEL_A_CTRL,
    SEL_B_DATA,
    SEL_B_CTRL
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= '1;
        else        st[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= '1;
        else        st[i] <= st[i-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic         data_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_sync,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '1;
      latch_q <= '1;
    end else begin
      if (ctrl_we) ctrl_q  <= wdata;
      if (data_we) latch_q <= wdata;
    end
  end

  assign oe = ~ctrl_q;

  for (genvar b = 0; b < W; b++) begin : g_rdmux
    assign rd_data[b] = ctrl_q[b] ? pad_sync[b] : latch_q[b];
  end

  AST_CTRL_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (oe == ~$past(wdata))); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(latch_q)); // R4
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_sync,
  input  logic [W-1:0] is_input,
  input  logic [W-1:0] enable,
  output logic         wake_req
);
  logic [W-1:0] prev_q;
  logic [W-1:0] fall;

  assign fall = prev_q & ~pad_sync & is_input & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '1;
      wake_req <= 1'b0;
    end else begin
      prev_q   <= pad_sync;
      wake_req <= |fall;
    end
  end

  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0 && $past(enable) == '0) |-> !wake_req); // R8
endmodule

// File: rtl/gpio_port_unit.sv
module gpio_port_unit
  import gpio_port_pkg::*;
#(
  parameter int             AW          = 8,
  parameter int             DW          = 8,
  parameter int             WA          = 8,
  parameter int             WB          = 3,
  parameter int             SYNC_STAGES = 2,
  parameter logic [AW-1:0]  ADDR_A_DATA = 8'h12,
  parameter logic [AW-1:0]  ADDR_A_CTRL = 8'h13,
  parameter logic [AW-1:0]  ADDR_B_DATA = 8'h14,
  parameter logic [AW-1:0]  ADDR_B_CTRL = 8'h15,
  parameter bit             PULL_A      = 1'b1,
  parameter bit             PULL_B      = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [WA-1:0] pa_in,
  output logic [WA-1:0] pa_oe,
  output logic [WA-1:0] pa_out,
  output logic [WA-1:0] pa_pu,
  input  logic [WB-1:0] pb_in,
  output logic [WB-1:0] pb_oe,
  output logic [WB-1:0] pb_out,
  output logic [WB-1:0] pb_pu,
  input  logic [WA-1:0] wake_en,
  output logic          wake_req
);
  reg_sel_e      sel;
  logic [WA-1:0] a_sync, a_ctrl, a_rd;
  logic [WB-1:0] b_sync, b_ctrl, b_rd;

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_A_DATA) sel = SEL_A_DATA;
    else if (bus_addr == ADDR_A_CTRL) sel = SEL_A_CTRL;
    else if (bus_addr == ADDR_B_DATA) sel = SEL_B_DATA;
    else if (bus_addr == ADDR_B_CTRL) sel = SEL_B_CTRL;
  end

  gpio_sync #(.W(WA), .STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .din(pa_in), .dout(a_sync));
  gpio_sync #(.W(WB), .STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .din(pb_in), .dout(b_sync));

  gpio_port_bank #(.W(WA)) u_bank_a (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(bus_wr && sel == SEL_A_CTRL),
    .data_we(bus_wr && sel == SEL_A_DATA),
    .wdata(bus_wdata[WA-1:0]), .pad_sync(a_sync),
    .ctrl_q(a_ctrl), .latch_q(pa_out), .oe(pa_oe), .rd_data(a_rd));

  gpio_port_bank #(.W(WB)) u_bank_b (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(bus_wr && sel == SEL_B_CTRL),
    .data_we(bus_wr && sel == SEL_B_DATA),
    .wdata(bus_wdata[WB-1:0]), .pad_sync(b_sync),
    .ctrl_q(b_ctrl), .latch_q(pb_out), .oe(pb_oe), .rd_data(b_rd));

  gpio_wake_det #(.W(WA)) u_wake (
    .clk(clk), .rst_n(rst_n), .pad_sync(a_sync),
    .is_input(a_ctrl), .enable(wake_en), .wake_req(wake_req));

  assign pa_pu = a_ctrl & {WA{PULL_A}};
  assign pb_pu = b_ctrl & {WB{PULL_B}};

  always_comb begin
    unique case (sel)
      SEL_A_DATA: bus_rdata = DW'(a_rd);
      SEL_A_CTRL: bus_rdata = DW'(a_ctrl);
      SEL_B_DATA: bus_rdata = DW'(b_rd);
      SEL_B_CTRL: bus_rdata = DW'(b_ctrl);
      default:    bus_rdata = '0;
    endcase
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0)); // R10
  AST_B_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_B_DATA || sel == SEL_B_CTRL) |-> (bus_rdata[DW-1:WB] == '0)); // R6
  AST_OE_OFF_WHEN_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_pu & pa_oe) == '0); // R9
endmodule

// File: tb/gpio_port_unit_test.sv
module gpio_port_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
  logic       bus_wr = 1'b0;
  logic [7:0] pa_in = 8'hFF, pa_oe, pa_out, pa_pu, wake_en = 8'h00;
  logic [2:0] pb_in = 3'h7, pb_oe, pb_out, pb_pu;
  logic       wake_req;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] m_ctl_a, m_lat_a, m_s1_a, m_s2_a, m_pv_a;
  logic [2:0] m_ctl_b, m_lat_b, m_s1_b, m_s2_b;
  logic       m_wake;

  always #10 clk = ~clk; // 50 MHz

  gpio_port_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_oe(pa_oe), .pa_out(pa_out), .pa_pu(pa_pu),
    .pb_in(pb_in), .pb_oe(pb_oe), .pb_out(pb_out), .pb_pu(pb_pu),
    .wake_en(wake_en), .wake_req(wake_req));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h12: return (m_ctl_a & m_s2_a) | (~m_ctl_a & m_lat_a);
      8'h13: return m_ctl_a;
      8'h14: return {5'b0, (m_ctl_b & m_s2_b) | (~m_ctl_b & m_lat_b)};
      8'h15: return {5'b0, m_ctl_b};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h12: return "R1 R3 R7 read A data";
      8'h13: return "R1 R2 read A dir";
      8'h14: return "R1 R3 R6 read B data";
      8'h15: return "R1 R6 read B dir";
      default: return "R10 unmapped read";
    endcase
  endfunction

  task automatic model_reset();
    m_ctl_a = '1; m_lat_a = '1; m_s1_a = '1; m_s2_a = '1; m_pv_a = '1;
    m_ctl_b = '1; m_lat_b = '1; m_s1_b = '1; m_s2_b = '1; m_wake = 1'b0;
  endtask

  task automatic check_all();
    chk(rd_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
    chk("R2 A output enable", pa_oe, ~m_ctl_a);
    chk("R2 B output enable", {5'b0, pb_oe}, {5'b0, ~m_ctl_b});
    chk("R4 A output value", pa_out, m_lat_a);
    chk("R4 R6 B output value", {5'b0, pb_out}, {5'b0, m_lat_b});
    chk("R9 A pull-up", pa_pu, m_ctl_a);
    chk("R9 B pull-up", {5'b0, pb_pu}, 8'h00);
    chk("R8 wake request", {7'b0, wake_req}, {7'b0, m_wake});
  endtask

  // one bus cycle: drive just after negedge, check, advance model at posedge
  task automatic cycle(input logic [7:0] a, input logic w, input logic [7:0] d,
                       input logic [7:0] pa, input logic [2:0] pb, input logic [7:0] we);
    logic nw;
    bus_addr = a; bus_wr = w; bus_wdata = d; pa_in = pa; pb_in = pb; wake_en = we;
    #1 check_all();
    @(posedge clk);
    nw = |(m_pv_a & ~m_s2_a & m_ctl_a & we);
    m_pv_a = m_s2_a; m_s2_a = m_s1_a; m_s1_a = pa;
    m_s2_b = m_s1_b; m_s1_b = pb;
    if (w) case (a)
      8'h12: m_lat_a = d;
      8'h13: m_ctl_a = d;
      8'h14: m_lat_b = d[2:0];
      8'h15: m_ctl_b = d[2:0];
      default: ;
    endcase
    m_wake = nw;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pa, we;
    logic [2:0] pb;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R5: reset state seen at the pins
    bus_addr = 8'h13; #1;
    chk("R5 reset dir A", bus_rdata, 8'hFF);
    chk("R5 reset oe A", pa_oe, 8'h00);
    chk("R5 reset out A", pa_out, 8'hFF);
    chk("R5 reset out B", {5'b0, pb_out}, 8'h07);
    chk("R5 reset wake", {7'b0, wake_req}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: upper B bits ignored on write, read 0
    cycle(8'h15, 1'b1, 8'hF8, 8'hFF, 3'h7, 8'h00);
    cycle(8'h15, 1'b0, 8'h00, 8'hFF, 3'h7, 8'h00);
    cycle(8'h14, 1'b1, 8'hFD, 8'hFF, 3'h7, 8'h00);
    cycle(8'h14, 1'b0, 8'h00, 8'hFF, 3'h7, 8'h00);
    // R3: mixed directions, pads low
    cycle(8'h13, 1'b1, 8'h0F, 8'h00, 3'h0, 8'h00);
    cycle(8'h12, 1'b1, 8'hA5, 8'h00, 3'h0, 8'h00);
    repeat (3) cycle(8'h12, 1'b0, 8'h00, 8'h00, 3'h0, 8'h00);
    // R10: unmapped write has no effect
    cycle(8'h16, 1'b1, 8'h00, 8'h00, 3'h0, 8'h00);
    cycle(8'h11, 1'b1, 8'h00, 8'h00, 3'h0, 8'h00);
    cycle(8'h13, 1'b0, 8'h00, 8'h00, 3'h0, 8'h00);
    // R8: wake on falling input line, then with option off
    cycle(8'h13, 1'b1, 8'hFF, 8'hFF, 3'h7, 8'h01);
    repeat (4) cycle(8'h12, 1'b0, 8'h00, 8'hFF, 3'h7, 8'h01);
    repeat (5) cycle(8'h12, 1'b0, 8'h00, 8'hFE, 3'h7, 8'h01);
    repeat (4) cycle(8'h12, 1'b0, 8'h00, 8'hFF, 3'h7, 8'h00);
    repeat (5) cycle(8'h12, 1'b0, 8'h00, 8'hFE, 3'h7, 8'h00);
    // R8: output line does not wake
    cycle(8'h13, 1'b1, 8'hFE, 8'hFF, 3'h7, 8'h01);
    repeat (5) cycle(8'h12, 1'b0, 8'h00, 8'hFE, 3'h7, 8'h01);

    // constrained random
    pa = 8'hFF; pb = 3'h7; we = 8'h00;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic       w;
      a = ($urandom % 4 != 0) ? 8'h12 + 8'($urandom % 4) : 8'($urandom);
      w = ($urandom % 3 == 0);
      if ($urandom % 4 == 0) pa = 8'($urandom);
      if ($urandom % 4 == 0) pb = 3'($urandom);
      if ($urandom % 16 == 0) we = 8'($urandom);
      cycle(a, w, 8'($urandom), pa, pb, we);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule